// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block sits on a processor's byte-wide register bus. It offers three 8-bit general-purpose ports, called A, B and C, and one write-only control register. A two-bit register index selects which of the four is accessed. Software writes a control word that sets the direction of each port. The same word can also turn ports A and B into strobed ports. In that case some port C pins carry the strobe, acknowledge, buffer-full and interrupt-request lines for the port that uses them.

In basic mode, ports A, B, the upper nibble of C and the lower nibble of C are each an input or an output, independently of the others. An output keeps the last value written to it in a latch. An input returns whatever is on its pins when it is read. In strobed input mode, a falling strobe captures the port pins into a holding latch and flags the buffer full. In strobed output mode, a processor write marks the buffer full on an active-low pin. A falling acknowledge from the peripheral then releases the buffer and raises an interrupt request.

The pins are split into an input, an output and an output enable, so the chip's pad ring builds the bidirectional drivers. Group A's bidirectional mode and the single-bit port C set/reset command are not provided.

Top module: `ppi_port`

## Requirements
- R1: After reset, every port is a basic-mode input: pa_oe, pb_oe and all pc_oe bits are 0, and the port A, B and C output latches are 0.
- R2: The register index maps 0 to port A, 1 to port B, 2 to port C and 3 to the control register. A control read returns 0. Control word fields:
  - bit 7 = 1: mode set.
  - bits 6..5: group A mode (00 basic, 01 strobed).
  - bit 4: port A direction.
  - bit 3: port C upper nibble direction.
  - bit 2: group B mode (0 basic, 1 strobed).
  - bit 1: port B direction.
  - bit 0: port C lower nibble direction.
  - For every direction bit, 1 means input and 0 means output.
- R3: A control write with bit 7 clear is ignored. So is a control write with bits 7 and 6 both set (bidirectional mode is unsupported). Neither changes any direction, latch or flag.
- R4: A basic-mode output port drives its latch on its pins with the enable set, and a read of it returns the latch.
- R5: A basic-mode input port returns its live pin values on a read.
- R6: The two port C nibbles take their directions from bits 3 and 0 independently. A port C read returns the driven value for output bits and the pin value for input bits.
- R7: An accepted mode-set word clears all three output latches and all handshake flags.
- R8: With group A strobed and A as input, a falling PC4 captures port A's pins and sets PC5 (buffer full) and PC3 (interrupt) to 1. Later pin changes do not alter the captured byte.
- R9: In strobed input mode, a processor read of port A clears PC5 and PC3.
- R10: With group A strobed and A as output, a write to port A drives the data, pulls PC7 (active-low buffer full) to 0 and clears PC3.
- R11: In strobed output mode, a falling PC6 (acknowledge) returns PC7 to 1 and sets PC3 to 1.
- R12: With group B strobed and B as input, a falling PC2 captures port B's pins and sets PC1 and PC0 to 1. A read of port B returns the captured byte and clears both.
- R13: With group B strobed and B as output, a write to port B pulls PC1 to 0. A falling PC2 returns PC1 to 1 and sets PC0 to 1.
- R14: Port C pins not taken by a handshake follow their nibble's direction and the port C latch. Handshake pins ignore the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Block select |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while sel and rd_en are high, else 0 |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-bit output enables |

## Verification
Basic mode is tried in two setups, an all-output word and a word with mixed nibble directions. The mixed word tells whether port C reads pick latch or pin bit by bit. Each strobed direction is run on both groups, and the captured byte is compared after the pins change. This separates a true holding latch from a pass-through. Ignored control words are written after a known latch value, so a wrongly accepted word would show up as a cleared latch or a changed enable.

// File: rtl/ppi_port.sv
module ppi_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  localparam logic [6:0] CTRL_RST = 7'b001_1011;

  logic [6:0] ctrl_q;
  logic [7:0] pa_q, pb_q, pc_q, pa_lat, pb_lat;
  logic [2:0] edge_d;
  logic       a_bf, a_irq, b_bf, b_irq;
  logic [7:0] hs_mask, hs_oe, hs_val, pc_rd;

  wire wr_a    = sel & wr_en & (addr == 2'd0);
  wire wr_b    = sel & wr_en & (addr == 2'd1);
  wire wr_c    = sel & wr_en & (addr == 2'd2);
  wire rd_a    = sel & rd_en & (addr == 2'd0);
  wire rd_b    = sel & rd_en & (addr == 2'd1);
  wire mode_wr = sel & wr_en & (addr == 2'd3) & wdata[7] & ~wdata[6];

  wire a_strb = (ctrl_q[6:5] == 2'b01);
  wire a_in   = ctrl_q[4];
  wire b_strb = ctrl_q[2];
  wire b_in   = ctrl_q[1];

  wire fall_b2 = edge_d[0] & ~pc_in[2];
  wire fall_a4 = edge_d[1] & ~pc_in[4];
  wire fall_a6 = edge_d[2] & ~pc_in[6];

  assign pa_oe  = ~ctrl_q[4];
  assign pb_oe  = ~ctrl_q[1];
  assign pa_out = pa_q;
  assign pb_out = pb_q;

  always_comb begin
    hs_mask = '0;
    hs_oe   = '0;
    hs_val  = '0;
    if (a_strb) begin
      hs_mask[3] = 1'b1;
      hs_oe[3]   = 1'b1;
      hs_val[3]  = a_irq;
      if (a_in) begin
        hs_mask[5:4] = 2'b11;
        hs_oe[5]     = 1'b1;
        hs_val[5]    = a_bf;
      end else begin
        hs_mask[7:6] = 2'b11;
        hs_oe[7]     = 1'b1;
        hs_val[7]    = ~a_bf;
      end
    end
    if (b_strb) begin
      hs_mask[2:0] = 3'b111;
      hs_oe[1:0]   = 2'b11;
      hs_val[0]    = b_irq;
      hs_val[1]    = b_in ? b_bf : ~b_bf;
    end
  end

  for (genvar i = 0; i < 8; i++) begin : g_pc
    localparam int DIR_BIT = (i >= 4) ? 3 : 0;
    assign pc_oe[i]  = hs_mask[i] ? hs_oe[i] : ~ctrl_q[DIR_BIT];
    assign pc_out[i] = hs_mask[i] ? hs_val[i] : pc_q[i];
    assign pc_rd[i]  = pc_oe[i] ? pc_out[i] : pc_in[i];
  end

  always_comb begin
    rdata = '0;
    if (sel && rd_en) begin
      case (addr)
        2'd0:    rdata = (a_strb && a_in) ? pa_lat : (pa_oe ? pa_q : pa_in);
        2'd1:    rdata = (b_strb && b_in) ? pb_lat : (pb_oe ? pb_q : pb_in);
        2'd2:    rdata = pc_rd;
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      pa_q   <= '0;
      pb_q   <= '0;
      pc_q   <= '0;
    end else if (mode_wr) begin
      ctrl_q <= wdata[6:0];
      pa_q   <= '0;
      pb_q   <= '0;
      pc_q   <= '0;
    end else begin
      if (wr_a) pa_q <= wdata;
      if (wr_b) pb_q <= wdata;
      if (wr_c) pc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) edge_d <= 3'b111;
    else     edge_d <= {pc_in[6], pc_in[4], pc_in[2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_lat <= '0;
      pb_lat <= '0;
    end else begin
      if (a_strb && a_in && fall_a4) pa_lat <= pa_in;
      if (b_strb && b_in && fall_b2) pb_lat <= pb_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      a_bf  <= 1'b0;
      a_irq <= 1'b0;
    end else if (a_strb) begin
      if (a_in) begin
        if (fall_a4) begin
          a_bf  <= 1'b1;
          a_irq <= 1'b1;
        end else if (rd_a) begin
          a_bf  <= 1'b0;
          a_irq <= 1'b0;
        end
      end else begin
        if (wr_a) begin
          a_bf  <= 1'b1;
          a_irq <= 1'b0;
        end else if (fall_a6) begin
          a_bf  <= 1'b0;
          a_irq <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      b_bf  <= 1'b0;
      b_irq <= 1'b0;
    end else if (b_strb) begin
      if (b_in) begin
        if (fall_b2) begin
          b_bf  <= 1'b1;
          b_irq <= 1'b1;
        end else if (rd_b) begin
          b_bf  <= 1'b0;
          b_irq <= 1'b0;
        end
      end else begin
        if (wr_b) begin
          b_bf  <= 1'b1;
          b_irq <= 1'b0;
        end else if (fall_b2) begin
          b_bf  <= 1'b0;
          b_irq <= 1'b1;
        end
      end
    end
  end

  a_r1_reset_inputs: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pa_oe && !pb_oe && pc_oe == 8'h00 && pa_out == 8'h00 && pb_out == 8'h00));

  a_r3_ignored_word: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && addr == 2'd3 && (!wdata[7] || wdata[6])) |=> $stable(ctrl_q));

  a_r7_mode_clears: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_out == 8'h00 && pb_out == 8'h00 && !a_irq && !b_irq));

  a_r8_strobe_sets_full: assert property (@(posedge clk) disable iff (rst)
    (a_strb && a_in && fall_a4 && !(sel && wr_en)) |=> (pc_out[5] && pc_out[3]));

  a_r9_read_clears_full: assert property (@(posedge clk) disable iff (rst)
    (a_strb && a_in && rd_a && !fall_a4 && !wr_en) |=> (!pc_out[5] && !pc_out[3]));

  a_r10_write_sets_obf: assert property (@(posedge clk) disable iff (rst)
    (a_strb && !a_in && wr_a) |=> (!pc_out[7] && !pc_out[3]));

  a_r11_ack_releases: assert property (@(posedge clk) disable iff (rst)
    (a_strb && !a_in && fall_a6 && !(sel && wr_en)) |=> (pc_out[7] && pc_out[3]));

endmodule

// File: tb/ppi_port_tb.sv
module ppi_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  ppi_port u_dut (
    .clk(clk), .rst(rst), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
    check("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    pa_in = 8'h6B;
    bus_rd(2'd0, rv);
    check("R5 read A input", rv, 8'h6B);
    bus_rd(2'd3, rv);
    check("R2 control reads 0", rv, 8'h00);
  endtask

  task automatic t_basic;
    bus_wr(2'd0, 8'h12);
    bus_wr(2'd3, 8'h80);
    check("R2 A out enable", {7'd0, pa_oe}, 8'h01);
    check("R2 B out enable", {7'd0, pb_oe}, 8'h01);
    check("R6 C all out", pc_oe, 8'hFF);
    check("R7 latch cleared", pa_out, 8'h00);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h81);
    check("R4 A drive", pa_out, 8'h5A);
    check("R4 B drive", pb_out, 8'hC3);
    check("R4 C drive", pc_out, 8'h81);
    bus_rd(2'd1, rv);
    check("R4 B readback", rv, 8'hC3);
    bus_wr(2'd3, 8'h88);
    check("R6 C upper in", pc_oe, 8'h0F);
    bus_wr(2'd2, 8'hA5);
    pc_in = 8'h3C;
    bus_rd(2'd2, rv);
    check("R6 C mixed read", rv, 8'h35);
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'h81);
    check("R6 C lower in", pc_oe, 8'hF0);
  endtask

  task automatic t_ignore;
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd3, 8'h00);
    check("R3 bit7 clear dir", pc_oe, 8'hF0);
    check("R3 bit7 clear latch", pa_out, 8'h77);
    bus_wr(2'd3, 8'hC0);
    check("R3 bidir word dir", pc_oe, 8'hF0);
    check("R3 bidir word latch", pa_out, 8'h77);
    bus_wr(2'd3, 8'h82);
    check("R5 B input oe", {7'd0, pb_oe}, 8'h00);
    pb_in = 8'hE4;
    bus_rd(2'd1, rv);
    check("R5 B input read", rv, 8'hE4);
  endtask

  task automatic t_a_strobe_in;
    bus_wr(2'd3, 8'hB0);
    check("R8 pc_oe layout", pc_oe, 8'hEF);
    check("R8 idle flags", pc_out & 8'h28, 8'h00);
    bus_wr(2'd2, 8'hFF);
    check("R14 free pins follow latch", pc_out, 8'hC7);
    bus_rd(2'd2, rv);
    check("R14 C read", rv, 8'hD7);
    pa_in = 8'h96;
    @(negedge clk); pc_in[4] = 1'b0;
    tick;
    check("R8 full and irq", pc_out & 8'h28, 8'h28);
    pa_in = 8'h11;
    pc_in[4] = 1'b1;
    tick;
    bus_rd(2'd0, rv);
    check("R8 captured byte", rv, 8'h96);
    check("R9 read clears", pc_out & 8'h28, 8'h00);
  endtask

  task automatic t_a_strobe_out;
    bus_wr(2'd3, 8'hA0);
    check("R10 pc_oe layout", pc_oe, 8'hBF);
    check("R10 idle obf high", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'd0, 8'hE7);
    check("R10 data", pa_out, 8'hE7);
    check("R10 obf low irq low", pc_out & 8'h88, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0;
    tick;
    check("R11 ack releases", pc_out & 8'h88, 8'h88);
    pc_in[6] = 1'b1;
    tick;
    bus_wr(2'd0, 8'h3E);
    check("R10 rewrite clears irq", pc_out & 8'h88, 8'h00);
  endtask

  task automatic t_b_strobe_in;
    bus_wr(2'd3, 8'h86);
    check("R12 idle", pc_out & 8'h03, 8'h00);
    pb_in = 8'h5D;
    @(negedge clk); pc_in[2] = 1'b0;
    tick;
    check("R12 full and irq", pc_out & 8'h03, 8'h03);
    pb_in = 8'h00;
    pc_in[2] = 1'b1;
    tick;
    bus_rd(2'd1, rv);
    check("R12 captured byte", rv, 8'h5D);
    check("R12 read clears", pc_out & 8'h03, 8'h00);
  endtask

  task automatic t_b_strobe_out;
    bus_wr(2'd3, 8'h84);
    check("R13 idle obf high", pc_out & 8'h03, 8'h02);
    bus_wr(2'd1, 8'h3A);
    check("R13 data", pb_out, 8'h3A);
    check("R13 obf low", pc_out & 8'h03, 8'h00);
    @(negedge clk); pc_in[2] = 1'b0;
    tick;
    check("R13 ack releases", pc_out & 8'h03, 8'h03);
    pc_in[2] = 1'b1;
    tick;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick;
    t_reset;
    t_basic;
    t_ignore;
    t_a_strobe_in;
    t_a_strobe_out;
    t_b_strobe_in;
    t_b_strobe_out;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule